// File: doc/BRIEF.md
# Interrupt Autovector Insertion Unit

This block gathers twenty-one USB event requests (frame start, the two setup events, bus reset, suspend, and sixteen bulk endpoints) into sticky flags. It drives them onto one shared interrupt line of an 8-bit microcontroller. Each flag has its own enable bit, and software clears a flag by writing a one to it. Because all sources share one line, the service entry would otherwise have to poll every flag to find the cause.

The unit removes that polling. The interrupt's vector location holds a three-byte jump: opcode, high address byte, low address byte. When the core fetches the opcode byte, the unit captures the highest-priority enabled pending source. When the core then fetches the low address byte, the unit replaces that byte on the code read bus with the source index times the table stride. The jump therefore lands in a table of four-byte entries, one per source. With autovectoring off, on any other address, or with nothing to report, code bytes pass through unchanged.

Top module: `irq_autovec`

## Requirements
- R1: A one-cycle high on `src_pulse[i]` sets `flags_o[i]` at that clock edge, and the flag stays set until cleared. Flags never change without a pulse or a clear.
- R2: A cycle with `clr_wr` high clears every flag whose `clr_mask` bit is 1. When a pulse and a clear hit the same bit in the same cycle, the flag stays set.
- R3: `irq_out` is high exactly when at least one flag is set whose `src_en` bit is 1. It follows `src_en` in the same cycle.
- R4: When `autovec_en` and `fetch_valid` are high, `fetch_addr` equals `VEC_LO_ADDR` (default 0x0045), and a source was captured, `cpu_rdata` equals the captured index times `STRIDE` (default 4).
- R5: Priority goes to the lowest index among sources that are both flagged and enabled. The index map is: 0 frame start, 1 setup data, 2 setup token, 3 bus reset, 4 suspend, and 5+n bulk endpoint n (n = 0..15).
- R6: The source is captured on the clock edge of the opcode fetch at `VEC_LO_ADDR-2` (default 0x0043). Flag or enable changes after that edge do not alter the substituted byte.
- R7: `cpu_rdata` equals `mem_rdata` whenever `autovec_en` is low, `fetch_valid` is low, or `fetch_addr` differs from `VEC_LO_ADDR`.
- R8: If no enabled flag was pending at the opcode fetch, the low-byte fetch passes `mem_rdata` through. A low-byte fetch consumes the capture, so a repeated low-byte fetch without a new opcode fetch also passes through.
- R9: After reset all flags are clear, `irq_out` is low and no source is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | NUM_SRC | One-cycle request pulse per source |
| src_en | input | NUM_SRC | Per-source enable |
| clr_wr | input | 1 | Clear strobe |
| clr_mask | input | NUM_SRC | Write-one-to-clear mask applied with `clr_wr` |
| autovec_en | input | 1 | Global autovector enable |
| fetch_valid | input | 1 | A code fetch is in progress this cycle |
| fetch_addr | input | ADDR_W | Code fetch address |
| mem_rdata | input | DATA_W | Byte read from code memory |
| cpu_rdata | output | DATA_W | Byte delivered to the core |
| irq_out | output | 1 | Shared interrupt request line |
| flags_o | output | NUM_SRC | Sticky request flags |

## Verification
The hardest situation to produce is a change in the pending set that falls between the opcode fetch and the low-byte fetch of one jump. The stimulus reaches it by fetching the opcode with only a low-priority endpoint flagged. It then pulses the frame-start source, which has higher priority, before fetching the low byte, and checks that the earlier endpoint's code still appears. A further opcode-to-low-byte sequence then shows that the new winner is reported. A repeated low-byte fetch shows that the capture is consumed.

// File: rtl/irq_autovec_pkg.sv
package irq_autovec_pkg;

   // Source index map; priority falls as the index rises
   localparam int SRC_FRAME      = 0;
   localparam int SRC_SETUP_DATA = 1;
   localparam int SRC_SETUP_TOK  = 2;
   localparam int SRC_BUS_RESET  = 3;
   localparam int SRC_SUSPEND    = 4;
   localparam int SRC_EP_BASE    = 5;
   localparam int NUM_EP         = 16;
   localparam int NUM_SRC_DFLT   = SRC_EP_BASE + NUM_EP;

   // Priority encoder build variants
   typedef enum logic [0:0] {
      ENC_LINEAR = 1'b0,
      ENC_SPLIT  = 1'b1
   } enc_style_e;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int N = 21
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         clr_wr_i,
   input  logic [N-1:0] clr_mask_i,
   output logic [N-1:0] flags_o
);

   generate
      if (N < 1) begin : g_bad_n
         $error("irq_flag_bank: N must be at least 1");
      end
   endgenerate

   // One sticky bit per source; a set in the same cycle beats a clear
   for (genvar i = 0; i < N; i++) begin : g_flag
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bit_q <= 1'b0;
         end else if (set_i[i]) begin
            bit_q <= 1'b1;
         end else if (clr_wr_i && clr_mask_i[i]) begin
            bit_q <= 1'b0;
         end
      end
      assign flags_o[i] = bit_q;
   end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
   import irq_autovec_pkg::*;
#(
   parameter int         N     = 21,
   parameter int         IDX_W = (N > 1) ? $clog2(N) : 1,
   parameter enc_style_e STYLE = ENC_LINEAR
) (
   input  logic [N-1:0]     req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);

   localparam int LO_N = N / 2;
   localparam int HI_N = N - LO_N;

   generate
      if (N < 2) begin : g_bad_n
         $error("irq_prio_enc: N must be at least 2");
      end
      if ((1 << IDX_W) < N) begin : g_bad_w
         $error("irq_prio_enc: IDX_W too narrow for N");
      end
   endgenerate

   generate
      if (STYLE == ENC_LINEAR) begin : g_linear
         // Downward scan so the lowest set index is written last
         always_comb begin
            any_o = 1'b0;
            idx_o = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req_i[i]) begin
                  any_o = 1'b1;
                  idx_o = IDX_W'(i);
               end
            end
         end
      end else begin : g_split
         // Two shallower halves; the lower half wins when it has a request
         logic             lo_any, hi_any;
         logic [IDX_W-1:0] lo_idx, hi_idx;

         always_comb begin
            lo_any = 1'b0;
            lo_idx = '0;
            for (int i = LO_N - 1; i >= 0; i--) begin
               if (req_i[i]) begin
                  lo_any = 1'b1;
                  lo_idx = IDX_W'(i);
               end
            end
         end

         always_comb begin
            hi_any = 1'b0;
            hi_idx = '0;
            for (int i = HI_N - 1; i >= 0; i--) begin
               if (req_i[LO_N + i]) begin
                  hi_any = 1'b1;
                  hi_idx = IDX_W'(LO_N + i);
               end
            end
         end

         assign any_o = lo_any | hi_any;
         assign idx_o = lo_any ? lo_idx : hi_idx;
      end
   endgenerate

endmodule

// File: rtl/irq_vec_capture.sv
module irq_vec_capture #(
   parameter int                ADDR_W  = 16,
   parameter int                IDX_W   = 5,
   parameter logic [ADDR_W-1:0] OP_ADDR = 'h43,
   parameter logic [ADDR_W-1:0] LO_ADDR = 'h45
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_valid_i,
   input  logic [ADDR_W-1:0] fetch_addr_i,
   input  logic              any_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic              held_valid_o,
   output logic [IDX_W-1:0]  held_idx_o
);

   generate
      if (OP_ADDR == LO_ADDR) begin : g_bad_addr
         $error("irq_vec_capture: opcode and low-byte addresses must differ");
      end
   endgenerate

   logic op_hit, lo_hit;
   assign op_hit = fetch_valid_i && (fetch_addr_i == OP_ADDR);
   assign lo_hit = fetch_valid_i && (fetch_addr_i == LO_ADDR);

   // The index is held until the next opcode fetch; the valid bit is
   // consumed by the low-byte fetch that uses it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_valid_o <= 1'b0;
         held_idx_o   <= '0;
      end else if (op_hit) begin
         held_valid_o <= any_i;
         held_idx_o   <= idx_i;
      end else if (lo_hit) begin
         held_valid_o <= 1'b0;
      end
   end

endmodule

// File: rtl/irq_fetch_mux.sv
module irq_fetch_mux #(
   parameter int                ADDR_W  = 16,
   parameter int                DATA_W  = 8,
   parameter int                IDX_W   = 5,
   parameter int                STRIDE  = 4,
   parameter logic [ADDR_W-1:0] LO_ADDR = 'h45
) (
   input  logic              autovec_en_i,
   input  logic              fetch_valid_i,
   input  logic [ADDR_W-1:0] fetch_addr_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              held_valid_i,
   input  logic [IDX_W-1:0]  held_idx_i,
   output logic [DATA_W-1:0] cpu_rdata_o
);

   localparam int SHIFT   = (STRIDE > 1) ? $clog2(STRIDE) : 0;
   localparam bit IS_POW2 = ((1 << SHIFT) == STRIDE);

   generate
      if (STRIDE < 1) begin : g_bad_stride
         $error("irq_fetch_mux: STRIDE must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] code;

   generate
      if (IS_POW2) begin : g_shift
         // Power-of-two stride: the code is just the index shifted up
         assign code = DATA_W'(held_idx_i) << SHIFT;
      end else begin : g_mul
         assign code = DATA_W'(int'(held_idx_i) * STRIDE);
      end
   endgenerate

   logic swap;
   assign swap = autovec_en_i && fetch_valid_i && held_valid_i &&
                 (fetch_addr_i == LO_ADDR);

   assign cpu_rdata_o = swap ? code : mem_rdata_i;

endmodule

// File: rtl/irq_autovec.sv
module irq_autovec
   import irq_autovec_pkg::*;
#(
   parameter int                NUM_SRC     = NUM_SRC_DFLT,
   parameter int                ADDR_W      = 16,
   parameter int                DATA_W      = 8,
   parameter int                STRIDE      = 4,
   parameter logic [ADDR_W-1:0] VEC_LO_ADDR = 'h45,
   parameter enc_style_e        ENC_STYLE   = ENC_LINEAR
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_pulse,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic               clr_wr,
   input  logic [NUM_SRC-1:0] clr_mask,
   input  logic               autovec_en,
   input  logic               fetch_valid,
   input  logic [ADDR_W-1:0]  fetch_addr,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic [DATA_W-1:0]  cpu_rdata,
   output logic               irq_out,
   output logic [NUM_SRC-1:0] flags_o
);

   localparam int                IDX_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam logic [ADDR_W-1:0] VEC_OP_ADDR = VEC_LO_ADDR - ADDR_W'(2);

   // Elaboration-time parameter checks
   generate
      if (NUM_SRC < 2) begin : g_bad_src
         $error("irq_autovec: NUM_SRC must be at least 2");
      end
      if ((NUM_SRC - 1) * STRIDE >= (1 << DATA_W)) begin : g_bad_range
         $error("irq_autovec: largest code does not fit in DATA_W");
      end
      if (VEC_LO_ADDR < 2) begin : g_bad_vec
         $error("irq_autovec: VEC_LO_ADDR must leave room for the opcode");
      end
   endgenerate

   logic [NUM_SRC-1:0] flags;
   logic [NUM_SRC-1:0] pending;
   logic               win_any;
   logic [IDX_W-1:0]   win_idx;
   logic               held_valid;
   logic [IDX_W-1:0]   held_idx;

   irq_flag_bank #(.N(NUM_SRC)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (src_pulse),
      .clr_wr_i   (clr_wr),
      .clr_mask_i (clr_mask),
      .flags_o    (flags)
   );

   assign pending = flags & src_en;
   assign irq_out = |pending;
   assign flags_o = flags;

   irq_prio_enc #(
      .N     (NUM_SRC),
      .IDX_W (IDX_W),
      .STYLE (ENC_STYLE)
   ) u_enc (
      .req_i (pending),
      .any_o (win_any),
      .idx_o (win_idx)
   );

   irq_vec_capture #(
      .ADDR_W  (ADDR_W),
      .IDX_W   (IDX_W),
      .OP_ADDR (VEC_OP_ADDR),
      .LO_ADDR (VEC_LO_ADDR)
   ) u_cap (
      .clk           (clk),
      .rst_n         (rst_n),
      .fetch_valid_i (fetch_valid),
      .fetch_addr_i  (fetch_addr),
      .any_i         (win_any),
      .idx_i         (win_idx),
      .held_valid_o  (held_valid),
      .held_idx_o    (held_idx)
   );

   irq_fetch_mux #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .IDX_W   (IDX_W),
      .STRIDE  (STRIDE),
      .LO_ADDR (VEC_LO_ADDR)
   ) u_mux (
      .autovec_en_i  (autovec_en),
      .fetch_valid_i (fetch_valid),
      .fetch_addr_i  (fetch_addr),
      .mem_rdata_i   (mem_rdata),
      .held_valid_i  (held_valid),
      .held_idx_i    (held_idx),
      .cpu_rdata_o   (cpu_rdata)
   );

endmodule

// File: rtl/irq_autovec_chk.sv
module irq_autovec_chk #(
   parameter int                NUM_SRC     = 21,
   parameter int                ADDR_W      = 16,
   parameter int                DATA_W      = 8,
   parameter int                IDX_W       = 5,
   parameter int                STRIDE      = 4,
   parameter logic [ADDR_W-1:0] VEC_LO_ADDR = 'h45
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_pulse,
   input logic [NUM_SRC-1:0] src_en,
   input logic               clr_wr,
   input logic [NUM_SRC-1:0] clr_mask,
   input logic               autovec_en,
   input logic               fetch_valid,
   input logic [ADDR_W-1:0]  fetch_addr,
   input logic [DATA_W-1:0]  mem_rdata,
   input logic [DATA_W-1:0]  cpu_rdata,
   input logic               irq_out,
   input logic [NUM_SRC-1:0] flags_o,
   input logic [IDX_W-1:0]   held_idx
);

   localparam logic [ADDR_W-1:0] OP_ADDR = VEC_LO_ADDR - ADDR_W'(2);

   assert_flag_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (src_pulse != '0) |=> ((flags_o & $past(src_pulse)) == $past(src_pulse)));

   assert_flag_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_pulse == '0) && !clr_wr) |=> $stable(flags_o));

   assert_flag_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> ((flags_o & $past(clr_mask & ~src_pulse)) == '0));

   assert_irq_needs_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (flags_o != '0));

   assert_code_stride_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rdata != mem_rdata) |->
         ((fetch_addr == VEC_LO_ADDR) && ((int'(cpu_rdata) % STRIDE) == 0)));

   assert_held_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetch_valid && (fetch_addr == OP_ADDR)) |=> $stable(held_idx));

   assert_pass_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!autovec_en || !fetch_valid) |-> (cpu_rdata == mem_rdata));

endmodule

bind irq_autovec irq_autovec_chk #(
   .NUM_SRC     (NUM_SRC),
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .IDX_W       (IDX_W),
   .STRIDE      (STRIDE),
   .VEC_LO_ADDR (VEC_LO_ADDR)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .src_pulse   (src_pulse),
   .src_en      (src_en),
   .clr_wr      (clr_wr),
   .clr_mask    (clr_mask),
   .autovec_en  (autovec_en),
   .fetch_valid (fetch_valid),
   .fetch_addr  (fetch_addr),
   .mem_rdata   (mem_rdata),
   .cpu_rdata   (cpu_rdata),
   .irq_out     (irq_out),
   .flags_o     (flags_o),
   .held_idx    (held_idx)
);

// File: tb/irq_autovec_test.sv
`timescale 1ns/1ps
module irq_autovec_test;

   localparam int          N      = 21;
   localparam logic [15:0] A_OP   = 16'h0043;
   localparam logic [15:0] A_HI   = 16'h0044;
   localparam logic [15:0] A_LO   = 16'h0045;
   localparam logic [7:0]  D_OP   = 8'h02;
   localparam logic [7:0]  D_HI   = 8'h12;
   localparam logic [7:0]  D_LO   = 8'hA5;

   typedef struct packed {
      logic [N-1:0] pulse;
      logic [N-1:0] en;
      logic [7:0]   expect_lo;
   } vec_t;

   // Expected low byte = winning index * 4, or D_LO when nothing qualifies
   localparam vec_t VECS [7] = '{
      '{pulse: 21'h000001, en: 21'h1FFFFF, expect_lo: 8'h00},
      '{pulse: 21'h000408, en: 21'h1FFFFF, expect_lo: 8'h0C},
      '{pulse: 21'h100000, en: 21'h1FFFFF, expect_lo: 8'h50},
      '{pulse: 21'h000082, en: 21'h1FFFFD, expect_lo: 8'h1C},
      '{pulse: 21'h000020, en: 21'h000000, expect_lo: 8'hA5},
      '{pulse: 21'h1FFFFF, en: 21'h081000, expect_lo: 8'h30},
      '{pulse: 21'h000014, en: 21'h1FFFFF, expect_lo: 8'h08}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] src_pulse = '0;
   logic [N-1:0] src_en = '0;
   logic         clr_wr = 1'b0;
   logic [N-1:0] clr_mask = '0;
   logic         autovec_en = 1'b0;
   logic         fetch_valid = 1'b0;
   logic [15:0]  fetch_addr = '0;
   logic [7:0]   mem_rdata = '0;
   logic [7:0]   cpu_rdata;
   logic         irq_out;
   logic [N-1:0] flags_o;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;

   always #2.5 clk = ~clk;

   irq_autovec uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .src_pulse   (src_pulse),
      .src_en      (src_en),
      .clr_wr      (clr_wr),
      .clr_mask    (clr_mask),
      .autovec_en  (autovec_en),
      .fetch_valid (fetch_valid),
      .fetch_addr  (fetch_addr),
      .mem_rdata   (mem_rdata),
      .cpu_rdata   (cpu_rdata),
      .irq_out     (irq_out),
      .flags_o     (flags_o)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic pulse(input logic [N-1:0] m);
      @(negedge clk);
      fetch_valid = 1'b0;
      src_pulse = m;
      @(negedge clk);
      src_pulse = '0;
      #1;
   endtask

   task automatic clear(input logic [N-1:0] m);
      @(negedge clk);
      fetch_valid = 1'b0;
      clr_wr = 1'b1;
      clr_mask = m;
      @(negedge clk);
      clr_wr = 1'b0;
      clr_mask = '0;
      #1;
   endtask

   task automatic fetch(input logic [15:0] a, input logic [7:0] d, output logic [7:0] q);
      @(negedge clk);
      fetch_valid = 1'b1;
      fetch_addr = a;
      mem_rdata = d;
      #1;
      q = cpu_rdata;
   endtask

   task automatic idle();
      @(negedge clk);
      fetch_valid = 1'b0;
      #1;
   endtask

   task automatic jump_seq(output logic [7:0] lo);
      logic [7:0] q;
      fetch(A_OP, D_OP, q);
      fetch(A_HI, D_HI, q);
      fetch(A_LO, D_LO, lo);
      idle();
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] q;
      repeat (3) @(negedge clk);
      // R9: reset state
      #1;
      check("R9 flags", 32'(flags_o), 32'h0);
      check("R9 irq", 32'(irq_out), 32'h0);
      rst_n = 1'b1;
      autovec_en = 1'b1;
      fetch(A_LO, D_LO, q);
      check("R9 no capture after reset", 32'(q), 32'(D_LO));
      idle();

      // Vector table: R1, R3, R4, R5
      foreach (VECS[k]) begin
         clear('1);
         src_en = VECS[k].en;
         pulse(VECS[k].pulse);
         check("R1 flags set", 32'(flags_o), 32'(VECS[k].pulse));
         check("R3 irq", 32'(irq_out), 32'(|(VECS[k].pulse & VECS[k].en)));
         jump_seq(q);
         check("R4/R5 low byte", 32'(q), 32'(VECS[k].expect_lo));
      end

      // R7: autovec disabled, other address, no fetch strobe
      clear('1);
      src_en = '1;
      pulse(21'h000008);
      fetch(A_OP, D_OP, q);
      check("R7 opcode byte untouched", 32'(q), 32'(D_OP));
      fetch(A_HI, D_HI, q);
      check("R7 high byte untouched", 32'(q), 32'(D_HI));
      autovec_en = 1'b0;
      fetch(A_LO, D_LO, q);
      check("R7 autovec off", 32'(q), 32'(D_LO));
      autovec_en = 1'b1;
      fetch(A_OP, D_OP, q);
      fetch(16'h0046, 8'h77, q);
      check("R7 other address", 32'(q), 32'h77);
      @(negedge clk);
      fetch_valid = 1'b0;
      fetch_addr = A_LO;
      mem_rdata = 8'h3B;
      #1;
      check("R7 no fetch strobe", 32'(cpu_rdata), 32'h3B);

      // R6: frame-start pulse after the opcode fetch does not change the code
      clear('1);
      pulse(21'h004000);          // endpoint 9 -> index 14
      fetch(A_OP, D_OP, q);
      pulse(21'h000001);          // frame start arrives late
      fetch(A_HI, D_HI, q);
      fetch(A_LO, D_LO, q);
      check("R6 frozen choice", 32'(q), 32'd56);
      // R8: capture consumed by the low-byte fetch
      fetch(A_LO, D_LO, q);
      check("R8 repeated low fetch", 32'(q), 32'(D_LO));
      idle();
      jump_seq(q);
      check("R5/R6 new winner", 32'(q), 32'h00);

      // R8: nothing enabled at opcode time
      src_en = '0;
      jump_seq(q);
      check("R8 none pending", 32'(q), 32'(D_LO));

      // R3: enable follows in the same cycle
      check("R3 disabled irq", 32'(irq_out), 32'h0);
      @(negedge clk);
      src_en = 21'h004000;
      #1;
      check("R3 enabled irq", 32'(irq_out), 32'h1);

      // R2: write-one-to-clear and set beating clear
      clear('1);
      pulse(21'h000140);
      @(negedge clk);
      clr_wr = 1'b1;
      clr_mask = 21'h000140;
      src_pulse = 21'h000040;
      @(negedge clk);
      clr_wr = 1'b0;
      clr_mask = '0;
      src_pulse = '0;
      #1;
      check("R2 set wins, other cleared", 32'(flags_o), 32'h40);
      clear(21'h000001);
      check("R2 untargeted flag kept", 32'(flags_o), 32'h40);
      clear(21'h000040);
      check("R2 cleared", 32'(flags_o), 32'h0);
      check("R2 irq drops", 32'(irq_out), 32'h0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule